// File: doc/BRIEF.md
# Memory Type Range Resolver

The resolver maps a 36-bit physical address to the cacheability type that applies to it. Four sources are consulted: a table of byte-wide type fields that divides the lowest megabyte into 64 KB, 16 KB and 4 KB pieces; a bank of variable ranges, each described by a base page, a page mask, a type and a valid bit; an optional write-back region that starts at 4 GB and ends at a programmed limit; and a programmable default type. A global enable forces every answer to uncacheable while it is clear.

Configuration is loaded through a simple write port (one register per write). Lookups are presented on a request port and answered two clock edges later with the resolved type and a hit flag that tells whether a range produced the answer or the default type did. Requests may be issued back to back, one per cycle. All variable ranges are compared in parallel and their types are folded pairwise in a balanced tree.

Top module: `mtr_resolver`

## Requirements
- R1: After synchronous reset, out_valid, out_hit and out_type are 0 and all configuration (global enable included) is cleared, so any lookup returns type 0 with out_hit 0.
- R2: A request with lk_valid high at clock edge N produces out_valid high for exactly one cycle after edge N+1, carrying that request's result; out_hit is 0 whenever out_valid is 0.
- R3: While the global enable (control bit 11) is 0, every result is uncacheable (0) with out_hit 0.
- R4: With the fixed-area enable (control bit 10) set, an address below 0x100000 takes the type of its fixed field and out_hit 1, ahead of every other source. Field n is written at cfg_addr n with the type in cfg_data[7:0]; fields 0-7 cover 64 KB each from 0x00000, fields 8-23 cover 16 KB each from 0x80000, fields 24-87 cover 4 KB each from 0xC0000.
- R5: With the fixed-area enable clear, addresses below 0x100000 resolve through the variable ranges and the default type like any other address.
- R6: Variable range i (base at cfg_addr 0x60+2i: page in cfg_data[35:12], type in cfg_data[7:0]; mask at cfg_addr 0x61+2i: page mask in cfg_data[35:12], valid in cfg_data[11]) matches when valid is 1 and address bits 35:12 AND mask equal base AND mask; a range with valid 0 has no effect.
- R7: When several variable ranges match, their types fold pairwise: uncacheable with anything gives uncacheable, write-back with write-through gives write-through, two other different types give uncacheable, equal types pass unchanged.
- R8: An address hit by no enabled source takes the default type (cfg_addr 0x70, cfg_data[7:0]) with out_hit 0.
- R9: The limit written at cfg_addr 0x71 (cfg_data[35:0]) is masked to bits 35:23; an address with any of bits 35:32 set and below the masked limit resolves to write-back (6) with out_hit 1, whatever the variable ranges say.
- R10: Type codes are 0 uncacheable, 1 write-combining, 4 write-through, 5 write-protect, 6 write-back; any other code, in any source, resolves as 0, so out_type never carries another code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register select |
| cfg_data | input | 36 | Configuration write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 36 | Physical address to resolve |
| out_valid | output | 1 | Result strobe, two edges after the request |
| out_type | output | 8 | Resolved cacheability type |
| out_hit | output | 1 | 1 when a fixed, top or variable range supplied the type |

## Verification
Random configurations are mixed with addresses aimed at the fixed area, inside a chosen variable range, around the top-region limit, below 4 GB and across the whole space; these separate fixed precedence, single and overlapping variable matches, top-region override and fall-through to the default. Directed cases pin the field boundaries of the fixed table, each pair of the combine rule, reserved codes in the default and a range, a disabled range, the limit masking edges, and the latency of exactly two edges.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  typedef logic [7:0] mtype_t;

  localparam mtype_t T_UC = 8'd0;
  localparam mtype_t T_WC = 8'd1;
  localparam mtype_t T_WT = 8'd4;
  localparam mtype_t T_WP = 8'd5;
  localparam mtype_t T_WB = 8'd6;

  typedef struct packed {
    logic   hit;
    mtype_t kind;
  } vote_t;

  // reserved codes collapse to uncacheable
  function automatic mtype_t norm_type(input mtype_t t);
    case (t)
      T_UC, T_WC, T_WT, T_WP, T_WB: norm_type = t;
      default:                      norm_type = T_UC;
    endcase
  endfunction

  function automatic mtype_t combine_type(input mtype_t a, input mtype_t b);
    if (a == T_UC || b == T_UC)                                  combine_type = T_UC;
    else if ((a == T_WB && b == T_WT) || (a == T_WT && b == T_WB)) combine_type = T_WT;
    else if (a != b)                                              combine_type = T_UC;
    else                                                          combine_type = a;
  endfunction

  function automatic vote_t merge_vote(input vote_t x, input vote_t y);
    vote_t r;
    r.hit = x.hit | y.hit;
    if (x.hit && y.hit) r.kind = combine_type(x.kind, y.kind);
    else if (x.hit)     r.kind = x.kind;
    else                r.kind = y.kind;
    return r;
  endfunction

endpackage

// File: rtl/mtr_fixed_ram.sv
module mtr_fixed_ram #(
  parameter int DEPTH = 88,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtr_cfg_regs.sv
module mtr_cfg_regs
  import mtr_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter int NVAR   = 8,
  parameter int AW     = 8,
  parameter int VAR_AD = 96,
  localparam int PG_W  = PA_W - 12,
  localparam int CTL_AD = VAR_AD + 2 * NVAR,
  localparam int TOP_AD = CTL_AD + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [PA_W-1:0]            wdata,
  output logic [NVAR-1:0][PG_W-1:0]  var_base,
  output logic [NVAR-1:0][PG_W-1:0]  var_mask,
  output mtype_t [NVAR-1:0]          var_type,
  output logic [NVAR-1:0]            var_vld,
  output mtype_t                     def_type,
  output logic                       fix_en,
  output logic                       glb_en,
  output logic [PA_W-1:0]            top_lim
);
  always_ff @(posedge clk) begin
    if (rst) begin
      var_base <= '0;
      var_mask <= '0;
      var_type <= '0;
      var_vld  <= '0;
      def_type <= T_UC;
      fix_en   <= 1'b0;
      glb_en   <= 1'b0;
      top_lim  <= '0;
    end else if (we) begin
      for (int i = 0; i < NVAR; i++) begin
        if (waddr == AW'(VAR_AD + 2 * i)) begin
          var_base[i] <= wdata[PA_W-1:12];
          var_type[i] <= wdata[7:0];
        end
        if (waddr == AW'(VAR_AD + 2 * i + 1)) begin
          var_mask[i] <= wdata[PA_W-1:12];
          var_vld[i]  <= wdata[11];
        end
      end
      if (waddr == AW'(CTL_AD)) begin
        def_type <= wdata[7:0];
        fix_en   <= wdata[10];
        glb_en   <= wdata[11];
      end
      if (waddr == AW'(TOP_AD)) top_lim <= wdata;
    end
  end
endmodule

// File: rtl/mtr_var_tree.sv
module mtr_var_tree
  import mtr_pkg::*;
#(
  parameter int PG_W = 24,
  parameter int NVAR = 8,
  localparam int NODES = 2 * NVAR - 1
) (
  input  logic [PG_W-1:0]            page,
  input  logic [NVAR-1:0][PG_W-1:0]  base,
  input  logic [NVAR-1:0][PG_W-1:0]  mask,
  input  mtype_t [NVAR-1:0]          kind,
  input  logic [NVAR-1:0]            vld,
  output vote_t                      result
);
  // heap-ordered tree: leaves at NVAR-1 .. NODES-1, root at 0 (NVAR a power of two)
  vote_t node [NODES];

  for (genvar i = 0; i < NVAR; i++) begin : g_leaf
    assign node[NVAR-1+i].hit  = vld[i] && ((page & mask[i]) == (base[i] & mask[i]));
    assign node[NVAR-1+i].kind = norm_type(kind[i]);
  end

  for (genvar k = 0; k < NVAR - 1; k++) begin : g_fold
    assign node[k] = merge_vote(node[2*k+1], node[2*k+2]);
  end

  assign result = node[0];
endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
  import mtr_pkg::*;
#(
  parameter int PA_W = 36,
  parameter int NVAR = 8,
  parameter int AW   = 8,
  localparam int PG_W  = PA_W - 12,
  localparam int FX_N  = 88,
  localparam int FX_IW = $clog2(FX_N),
  localparam logic [PA_W-1:0] TOP_GRAN = ~PA_W'(23'h7F_FFFF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [PA_W-1:0] cfg_data,
  input  logic            lk_valid,
  input  logic [PA_W-1:0] lk_addr,
  output logic            out_valid,
  output logic [7:0]      out_type,
  output logic            out_hit
);
  logic [NVAR-1:0][PG_W-1:0] var_base, var_mask;
  mtype_t [NVAR-1:0]         var_type;
  logic [NVAR-1:0]           var_vld;
  mtype_t                    def_type;
  logic                      fix_en, glb_en;
  logic [PA_W-1:0]           top_lim;

  mtr_cfg_regs #(.PA_W(PA_W), .NVAR(NVAR), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_data),
    .var_base(var_base), .var_mask(var_mask), .var_type(var_type), .var_vld(var_vld),
    .def_type(def_type), .fix_en(fix_en), .glb_en(glb_en), .top_lim(top_lim)
  );

  // fixed-area index: 8 x 64K, 16 x 16K, 64 x 4K
  logic [FX_IW-1:0] fx_idx;
  always_comb begin
    if (!lk_addr[19])      fx_idx = FX_IW'(lk_addr[18:16]);
    else if (!lk_addr[18]) fx_idx = FX_IW'(8)  + FX_IW'(lk_addr[17:14]);
    else                   fx_idx = FX_IW'(24) + FX_IW'(lk_addr[17:12]);
  end

  logic   fx_we;
  mtype_t fx_q;
  assign fx_we = cfg_we && (cfg_addr < AW'(FX_N));

  mtr_fixed_ram #(.DEPTH(FX_N)) u_fx (
    .clk(clk), .we(fx_we), .waddr(cfg_addr[FX_IW-1:0]), .wdata(cfg_data[7:0]),
    .raddr(fx_idx), .rdata(fx_q)
  );

  vote_t var_vote;
  mtr_var_tree #(.PG_W(PG_W), .NVAR(NVAR)) u_tree (
    .page(lk_addr[PA_W-1:12]), .base(var_base), .mask(var_mask),
    .kind(var_type), .vld(var_vld), .result(var_vote)
  );

  logic low_mb, top_hit;
  assign low_mb  = (lk_addr[PA_W-1:20] == '0);
  assign top_hit = (|lk_addr[PA_W-1:32]) && (lk_addr < (top_lim & TOP_GRAN));

  // stage 1
  logic   s1_v, s1_low, s1_top, s1_glb, s1_fix;
  vote_t  s1_var;
  mtype_t s1_def;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_low <= 1'b0; s1_top <= 1'b0;
      s1_glb <= 1'b0; s1_fix <= 1'b0; s1_var <= '0; s1_def <= T_UC;
    end else begin
      s1_v   <= lk_valid;
      s1_low <= low_mb;
      s1_top <= top_hit;
      s1_glb <= glb_en;
      s1_fix <= fix_en;
      s1_var <= var_vote;
      s1_def <= def_type;
    end
  end

  // stage 2: priority select
  mtype_t sel_type;
  logic   sel_hit;
  always_comb begin
    if (!s1_glb)              begin sel_type = T_UC;            sel_hit = 1'b0; end
    else if (s1_fix && s1_low) begin sel_type = norm_type(fx_q); sel_hit = 1'b1; end
    else if (s1_top)          begin sel_type = T_WB;            sel_hit = 1'b1; end
    else if (s1_var.hit)      begin sel_type = s1_var.kind;     sel_hit = 1'b1; end
    else                      begin sel_type = norm_type(s1_def); sel_hit = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_type  <= T_UC;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= s1_v;
      out_hit   <= s1_v && sel_hit;
      if (s1_v) out_type <= sel_type;
    end
  end
endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk (
  input logic       clk,
  input logic       rst,
  input logic       lk_valid,
  input logic       glb_en,
  input logic       out_valid,
  input logic [7:0] out_type,
  input logic       out_hit
);
  logic v1, v2, e1, e2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; e1 <= 1'b0; e2 <= 1'b0;
    end else begin
      v1 <= lk_valid; v2 <= v1;
      e1 <= glb_en;   e2 <= e1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_hit);

  assert_disabled_uc_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !e2) |-> (out_type == 8'd0 && !out_hit));

  assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_hit) |-> e2);

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type == 8'd0 || out_type == 8'd1 || out_type == 8'd4 ||
                   out_type == 8'd5 || out_type == 8'd6));
endmodule

bind mtr_resolver mtr_resolver_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .glb_en(glb_en),
  .out_valid(out_valid), .out_type(out_type), .out_hit(out_hit)
);

// File: tb/mtr_resolver_tb.sv
`timescale 1ns/1ps
module mtr_resolver_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [35:0] cfg_data;
  logic        lk_valid;
  logic [35:0] lk_addr;
  logic        out_valid;
  logic [7:0]  out_type;
  logic        out_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtr_resolver u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .out_valid(out_valid), .out_type(out_type), .out_hit(out_hit)
  );

  // mirror of programmed configuration
  logic [7:0]  m_fix [88];
  logic [23:0] m_base [8];
  logic [23:0] m_mask [8];
  logic [7:0]  m_type [8];
  logic        m_vld  [8];
  logic [7:0]  m_def;
  logic        m_fen, m_gen;
  logic [35:0] m_lim;

  function automatic logic [7:0] b_norm(input logic [7:0] t);
    if (t == 0 || t == 1 || t == 4 || t == 5 || t == 6) return t;
    return 8'd0;
  endfunction

  function automatic logic [7:0] b_comb(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'd0;
    if ((a == 6 && b == 4) || (a == 4 && b == 6)) return 8'd4;
    if (a != b) return 8'd0;
    return a;
  endfunction

  task automatic model(input logic [35:0] a, output logic [7:0] t, output logic h,
                       output string tag);
    int idx, n;
    logic [7:0] acc;
    logic [35:0] lim;
    lim = {m_lim[35:23], 23'd0};
    if (!m_gen) begin t = 0; h = 0; tag = "R3"; return; end
    if (m_fen && a < 36'h100000) begin
      if (a < 36'h80000)      idx = int'(a >> 16);
      else if (a < 36'hC0000) idx = 8 + int'((a - 36'h80000) >> 14);
      else                    idx = 24 + int'((a - 36'hC0000) >> 12);
      t = b_norm(m_fix[idx]); h = 1; tag = "R4"; return;
    end
    if (a >= 36'h1_0000_0000 && a < lim) begin t = 6; h = 1; tag = "R9"; return; end
    n = 0; acc = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_vld[i] && (((a[35:12] ^ m_base[i]) & m_mask[i]) == 24'd0)) begin
        acc = (n == 0) ? b_norm(m_type[i]) : b_comb(acc, b_norm(m_type[i]));
        n++;
      end
    end
    if (n > 0) begin t = acc; h = 1; tag = (n > 1) ? "R7" : "R6"; return; end
    t = b_norm(m_def); h = 0; tag = "R8";
  endtask

  task automatic wr(input logic [7:0] ad, input logic [35:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_fix(input int n, input logic [7:0] t);
    m_fix[n] = t; wr(8'(n), {28'd0, t});
  endtask
  task automatic set_var(input int i, input logic [23:0] b, input logic [23:0] m,
                         input logic [7:0] t, input logic v);
    m_base[i] = b; m_mask[i] = m; m_type[i] = t; m_vld[i] = v;
    wr(8'(8'h60 + 2 * i), {b, 4'd0, t});
    wr(8'(8'h61 + 2 * i), {m, v, 11'd0});
  endtask
  task automatic set_ctl(input logic g, input logic f, input logic [7:0] d);
    m_gen = g; m_fen = f; m_def = d;
    wr(8'h70, {24'd0, g, f, 2'b00, d});
  endtask
  task automatic set_lim(input logic [35:0] l);
    m_lim = l; wr(8'h71, l);
  endtask

  function automatic logic [7:0] rtype();
    case ($urandom % 9)
      0: return 8'd0; 1: return 8'd1; 2: return 8'd4; 3: return 8'd5;
      4, 5: return 8'd6; 6: return 8'd2; 7: return 8'd4; default: return 8'd7;
    endcase
  endfunction

  task automatic fail(input string req, input string what, input logic [35:0] a,
                      input int act, input int exp);
    errors++;
    $display("FAIL %s %s addr=%h actual=%0d expected=%0d", req, what, a, act, exp);
  endtask

  task automatic lookup(input logic [35:0] a, input string tag_in);
    logic [7:0] et; logic eh; string tag;
    model(a, et, eh, tag);
    if (tag_in != "") tag = tag_in;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1) fail(tag, "valid", a, int'(out_valid), 1);
    else if (out_type !== et) fail(tag, "type", a, int'(out_type), int'(et));
    else if (out_hit !== eh) fail(tag, "hit", a, int'(out_hit), int'(eh));
  endtask

  task automatic rand_cfg();
    for (int n = 0; n < 88; n++) set_fix(n, rtype());
    for (int i = 0; i < 8; i++) begin
      logic [23:0] m; int k;
      k = $urandom_range(0, 20);
      m = 24'hFFFFFF << k;
      set_var(i, 24'($urandom) & m, m, rtype(), ($urandom % 4) != 0);
    end
    set_lim(($urandom % 4 == 0) ? 36'd0 : {4'($urandom), 32'($urandom)});
    set_ctl(($urandom % 8) != 0, ($urandom % 4) != 0, rtype());
  endtask

  function automatic logic [35:0] raddr();
    int i;
    logic [35:0] lim;
    lim = {m_lim[35:23], 23'd0};
    i = $urandom % 8;
    case ($urandom % 5)
      0: return {16'd0, 20'($urandom)};
      1: return {m_base[i] | (24'($urandom) & ~m_mask[i]), 12'($urandom)};
      2: return lim + 36'($signed(12'($urandom)));
      3: return {4'($urandom), 32'($urandom)};
      default: return {4'd0, 32'($urandom)};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; lk_valid = 1'b0; lk_addr = '0;
    m_def = 0; m_fen = 0; m_gen = 0; m_lim = 0;
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_mask[i] = 0; m_type[i] = 0; m_vld[i] = 0; end
    for (int n = 0; n < 88; n++) m_fix[n] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_type !== 8'd0)
      fail("R1", "reset outputs", 36'd0, int'({out_valid, out_hit, out_type}), 0);
    lookup(36'h0_1234_5000, "R1");

    // load all fixed fields, enable with default WB
    for (int n = 0; n < 88; n++) set_fix(n, 8'(n % 7));
    set_fix(7, 8'd5); set_fix(8, 8'd1); set_fix(23, 8'd4); set_fix(24, 8'd6); set_fix(87, 8'd1);
    set_ctl(1'b1, 1'b1, 8'd6);
    // R4: fixed field boundaries
    lookup(36'h7FFFF, "R4"); lookup(36'h80000, "R4"); lookup(36'hBFFFF, "R4");
    lookup(36'hC0000, "R4"); lookup(36'hFFFFF, "R4"); lookup(36'h100000, "R8");
    lookup(36'h2000, "R10");

    // R6/R7: overlapping ranges
    set_var(0, 24'h10000, 24'hFFF000, 8'd6, 1'b1);   // 256 MB.. 16 MB WB
    set_var(1, 24'h10000, 24'hFFFF00, 8'd4, 1'b1);   // 1 MB WT inside
    set_var(2, 24'h10100, 24'hFFFF00, 8'd1, 1'b1);   // WC inside WB
    set_var(3, 24'h10200, 24'hFFFF00, 8'd0, 1'b1);   // UC inside WB
    set_var(4, 24'h10300, 24'hFFFF00, 8'd6, 1'b1);   // WB inside WB
    set_var(5, 24'h20000, 24'hFFFF00, 8'd7, 1'b1);   // reserved type
    set_var(6, 24'h30000, 24'hFFFF00, 8'd6, 1'b0);   // disabled
    set_var(7, 24'h0, 24'hFFFFFF, 8'd0, 1'b0);
    lookup(36'h0_1000_0000, "R7"); lookup(36'h0_1010_0000, "R7");
    lookup(36'h0_1020_0000, "R7"); lookup(36'h0_1030_0000, "R7");
    lookup(36'h0_1080_0000, "R6"); lookup(36'h0_2000_0000, "R10");
    lookup(36'h0_3000_0000, "R6");
    // R5: fixed area off, sub-1MB goes through variable ranges
    set_var(7, 24'h00000, 24'hFFFF00, 8'd5, 1'b1);
    set_ctl(1'b1, 1'b0, 8'd2);
    lookup(36'h7FFFF, "R5"); lookup(36'h0_4000_0000, "R10");
    // R9: top region, limit masked to 8 MB
    set_var(6, 24'h100000, 24'hF00000, 8'd0, 1'b1);  // UC over 4G..8G
    set_lim(36'h1_0FFF_FFFF);
    lookup(36'h0_FFFF_FFFF, "R9"); lookup(36'h1_0000_0000, "R9");
    lookup(36'h1_0F7F_FFFF, "R9"); lookup(36'h1_0F80_0000, "R9");
    // R3: global disable
    set_ctl(1'b0, 1'b1, 8'd6);
    lookup(36'h1000, "R3"); lookup(36'h1_0000_0000, "R3");
    set_ctl(1'b1, 1'b1, 8'd6);

    // R2: latency of exactly two edges, single-cycle strobe
    @(negedge clk); lk_valid = 1'b1; lk_addr = 36'h0_1010_0000;
    @(negedge clk); lk_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0) fail("R2", "early valid", lk_addr, int'(out_valid), 0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || out_type !== 8'd0) fail("R2", "on-time result", lk_addr, int'(out_type), 0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0) fail("R2", "strobe width", lk_addr, int'(out_valid), 0);

    // random configurations
    for (int r = 0; r < 8; r++) begin
      rand_cfg();
      for (int j = 0; j < 60; j++) lookup(raddr(), "");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule